// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This block keeps a 64-bit product register split into a high word (HI) and a low word (LO). It multiplies two 32-bit operands in signed or unsigned form. The 64-bit product can replace the register pair, be added to it, or be subtracted from it. It also loads either half directly and reads either half back. A three-operand multiply form writes the signed product into HI:LO and also returns the low 32 bits as a general-register result.

Every operation is presented with a one-cycle valid strobe and completes at the next rising clock edge, so a new operation can be accepted on every cycle. The register pair and the result port are registered outputs. A read issued right after a write therefore sees the written value.

Top module: `hilo_mac_unit`

## Requirements
- R1: While the synchronous active-high reset is held, and at the first edge after it is released, `hi_q`, `lo_q`, `res_q` and `res_valid` read 0.
- R2: Opcode 0 (signed multiply) replaces HI:LO with the 64-bit two's complement product of the operands. For example, 0x80000000 times 0x80000000 gives 0x4000000000000000.
- R3: Opcode 1 (unsigned multiply) replaces HI:LO with the 64-bit unsigned product. For example, 0xFFFFFFFF times 0xFFFFFFFF gives 0xFFFFFFFE00000001.
- R4: Opcodes 2 (signed) and 3 (unsigned) add the product to the old HI:LO modulo 2^64. A carry out of the low word increments HI.
- R5: Opcodes 4 (signed) and 5 (unsigned) subtract the product from the old HI:LO modulo 2^64. A borrow out of the low word decrements HI.
- R6: Opcode 6 (three-operand multiply) writes the signed product into HI:LO. One cycle later it drives the low 32 bits of that product on `res_q`, with `res_valid` high for that cycle.
- R7: Opcode 7 loads `src_a` into HI and opcode 8 loads `src_a` into LO. In both cases the other half is unchanged.
- R8: Opcodes 9 and 10 return HI and LO respectively, as they stood when the request was accepted. The value appears on `res_q` with `res_valid` high one cycle later, and HI and LO are unchanged.
- R9: A cycle with `in_valid` low, or with opcode 11 to 15, leaves HI and LO unchanged and gives `res_valid` low on the next cycle.
- R10: Each accepted operation is visible on the outputs after exactly one clock edge. Back-to-back operations on consecutive cycles each take effect in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe, one operation per cycle |
| in_op | input | 4 | Opcode (see R2 to R9) |
| src_a | input | 32 | First operand; also the move-to data |
| src_b | input | 32 | Second operand |
| hi_q | output | 32 | High word of the product register |
| lo_q | output | 32 | Low word of the product register |
| res_q | output | 32 | General-register result of opcodes 6, 9 and 10 |
| res_valid | output | 1 | High for one cycle when `res_q` holds a new result |

## Verification
A wrong value in HI or LO appears on `hi_q` or `lo_q` at the very next edge, because both halves are outputs. A lost carry or borrow shows up only when the low-word sum crosses 2^32. The bench therefore seeds LO with 0xFFFFFFFF or 0 before accumulating. Errors in the sign extension show up only for negative operands, which is why extreme operands are mixed into the random stream. A wrong read-back path stays hidden until the next move-from request, and then appears on `res_q` one cycle later.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_MUL_S   = 4'd0,
    OP_MUL_U   = 4'd1,
    OP_MAC_S   = 4'd2,
    OP_MAC_U   = 4'd3,
    OP_MSB_S   = 4'd4,
    OP_MSB_U   = 4'd5,
    OP_MUL3    = 4'd6,
    OP_LD_HI   = 4'd7,
    OP_LD_LO   = 4'd8,
    OP_RD_HI   = 4'd9,
    OP_RD_LO   = 4'd10
  } hilo_op_e;

  typedef enum logic [1:0] {
    ACC_SET = 2'd0,
    ACC_ADD = 2'd1,
    ACC_SUB = 2'd2
  } acc_mode_e;
endpackage

// File: rtl/hilo_mult.sv
module hilo_mult #(
  parameter int W = 32
) (
  input  logic            is_signed,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  output logic [2*W-1:0]  prod
);
  localparam int DW = 2 * W;

  logic          ext_a, ext_b;
  logic [DW-1:0] wide_a, wide_b;

  // Extend each operand to full product width; the low DW bits of the
  // product of the extended values are exact for both signed and unsigned.
  always_comb begin
    ext_a  = is_signed & op_a[W-1];
    ext_b  = is_signed & op_b[W-1];
    wide_a = {{W{ext_a}}, op_a};
    wide_b = {{W{ext_b}}, op_b};
    prod   = wide_a * wide_b;
  end
endmodule

// File: rtl/hilo_accum.sv
module hilo_accum
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  acc_mode_e       mode,
  input  logic [2*W-1:0]  acc,
  input  logic [2*W-1:0]  prod,
  output logic [2*W-1:0]  nxt
);
  // One full-width add or subtract: carry and borrow cross the word
  // boundary inside the adder, not in a separate correction step.
  always_comb begin
    unique case (mode)
      ACC_ADD: nxt = acc + prod;
      ACC_SUB: nxt = acc - prod;
      default: nxt = prod;
    endcase
  end
endmodule

// File: rtl/hilo_mac_unit.sv
module hilo_mac_unit
  import hilo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [OPW-1:0]       in_op,
  input  logic [W-1:0]         src_a,
  input  logic [W-1:0]         src_b,
  output logic [W-1:0]         hi_q,
  output logic [W-1:0]         lo_q,
  output logic [W-1:0]         res_q,
  output logic                 res_valid
);
  localparam int DW = 2 * W;

  hilo_op_e      op_e;
  logic          mul_signed;
  acc_mode_e     acc_mode;
  logic          wr_pair, wr_hi, wr_lo, rd_hi, rd_lo, rd_prod;
  logic [DW-1:0] prod, pair_nxt;

  assign op_e = hilo_op_e'(in_op);

  always_comb begin
    mul_signed = 1'b0;
    acc_mode   = ACC_SET;
    wr_pair    = 1'b0;
    wr_hi      = 1'b0;
    wr_lo      = 1'b0;
    rd_hi      = 1'b0;
    rd_lo      = 1'b0;
    rd_prod    = 1'b0;
    if (in_valid) begin
      case (op_e)
        OP_MUL_S: begin wr_pair = 1'b1; mul_signed = 1'b1; end
        OP_MUL_U: begin wr_pair = 1'b1; end
        OP_MAC_S: begin wr_pair = 1'b1; mul_signed = 1'b1; acc_mode = ACC_ADD; end
        OP_MAC_U: begin wr_pair = 1'b1; acc_mode = ACC_ADD; end
        OP_MSB_S: begin wr_pair = 1'b1; mul_signed = 1'b1; acc_mode = ACC_SUB; end
        OP_MSB_U: begin wr_pair = 1'b1; acc_mode = ACC_SUB; end
        OP_MUL3:  begin wr_pair = 1'b1; mul_signed = 1'b1; rd_prod = 1'b1; end
        OP_LD_HI: wr_hi = 1'b1;
        OP_LD_LO: wr_lo = 1'b1;
        OP_RD_HI: rd_hi = 1'b1;
        OP_RD_LO: rd_lo = 1'b1;
        default: ;
      endcase
    end
  end

  hilo_mult #(.W(W)) i_mult (
    .is_signed (mul_signed),
    .op_a      (src_a),
    .op_b      (src_b),
    .prod      (prod)
  );

  hilo_accum #(.W(W)) i_accum (
    .mode (acc_mode),
    .acc  ({hi_q, lo_q}),
    .prod (prod),
    .nxt  (pair_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q      <= '0;
      lo_q      <= '0;
      res_q     <= '0;
      res_valid <= 1'b0;
    end else begin
      if (wr_pair) begin
        hi_q <= pair_nxt[DW-1:W];
        lo_q <= pair_nxt[W-1:0];
      end
      if (wr_hi) hi_q <= src_a;
      if (wr_lo) lo_q <= src_a;
      res_valid <= rd_hi | rd_lo | rd_prod;
      if (rd_prod)    res_q <= prod[W-1:0];
      else if (rd_hi) res_q <= hi_q;
      else if (rd_lo) res_q <= lo_q;
    end
  end

  // R3: unsigned multiply result at the ports one edge later
  a_r3_unsigned_product: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd1) |=>
      ({hi_q, lo_q} == ({{W{1'b0}}, $past(src_a)} * {{W{1'b0}}, $past(src_b)})));

  // R4: unsigned accumulate adds onto the previous pair
  a_r4_accum_add: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd3) |=>
      ({hi_q, lo_q} == $past({hi_q, lo_q}) +
                       ({{W{1'b0}}, $past(src_a)} * {{W{1'b0}}, $past(src_b)})));

  // R5: unsigned accumulate subtracts from the previous pair
  a_r5_accum_sub: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd5) |=>
      ({hi_q, lo_q} == $past({hi_q, lo_q}) -
                       ({{W{1'b0}}, $past(src_a)} * {{W{1'b0}}, $past(src_b)})));

  // R7: loading HI leaves LO untouched
  a_r7_load_hi_only: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd7) |=> (hi_q == $past(src_a) && $stable(lo_q)));

  // R8: read-back returns the old HI and does not disturb the pair
  a_r8_read_hi: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd9) |=>
      (res_valid && res_q == $past(hi_q) && $stable(hi_q) && $stable(lo_q)));

  // R9: idle cycles hold the pair and raise no result
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_valid) |=> ($stable(hi_q) && $stable(lo_q) && !res_valid));
endmodule

// File: tb/test_hilo_mac_unit.sv
module test_hilo_mac_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [3:0]    in_op = '0;
  logic [W-1:0]  src_a = '0;
  logic [W-1:0]  src_b = '0;
  logic [W-1:0]  hi_q, lo_q, res_q;
  logic          res_valid;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [63:0]  pair;
    logic         rv;
    logic [W-1:0] res;
    string        tag;
  } exp_t;

  exp_t        sbq[$];
  logic [63:0] m_pair = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hilo_mac_unit #(.W(W)) i_hilo_mac_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .src_a(src_a), .src_b(src_b), .hi_q(hi_q), .lo_q(lo_q),
    .res_q(res_q), .res_valid(res_valid)
  );

  function automatic logic [63:0] sprod(input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    return 64'(sa * sb);
  endfunction

  function automatic logic [63:0] uprod(input logic [W-1:0] a, input logic [W-1:0] b);
    return {32'b0, a} * {32'b0, b};
  endfunction

  // Driver: apply one cycle of stimulus and push the expected outcome
  task automatic drive(input logic v, input logic [3:0] op,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    @(negedge clk);
    in_valid = v; in_op = op; src_a = a; src_b = b;
    e.rv = 1'b0; e.res = '0; e.tag = "R9";
    if (v) begin
      case (op)
        4'd0: begin m_pair = sprod(a, b); e.tag = "R2"; end
        4'd1: begin m_pair = uprod(a, b); e.tag = "R3"; end
        4'd2: begin m_pair = m_pair + sprod(a, b); e.tag = "R4"; end
        4'd3: begin m_pair = m_pair + uprod(a, b); e.tag = "R4"; end
        4'd4: begin m_pair = m_pair - sprod(a, b); e.tag = "R5"; end
        4'd5: begin m_pair = m_pair - uprod(a, b); e.tag = "R5"; end
        4'd6: begin m_pair = sprod(a, b); e.rv = 1'b1; e.res = m_pair[31:0]; e.tag = "R6"; end
        4'd7: begin m_pair[63:32] = a; e.tag = "R7"; end
        4'd8: begin m_pair[31:0] = a; e.tag = "R7"; end
        4'd9: begin e.rv = 1'b1; e.res = m_pair[63:32]; e.tag = "R8"; end
        4'd10: begin e.rv = 1'b1; e.res = m_pair[31:0]; e.tag = "R8"; end
        default: e.tag = "R9";
      endcase
    end
    e.pair = m_pair;
    sbq.push_back(e);
  endtask

  // Monitor: one expected item per clock edge, compared a quarter period later (R10)
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      checks++;
      if ({hi_q, lo_q} !== e.pair || res_valid !== e.rv ||
          (e.rv && res_q !== e.res)) begin
        errors++;
        $display("FAIL %s R10 hi:lo=%h rv=%b res=%h expected hi:lo=%h rv=%b res=%h",
                 e.tag, {hi_q, lo_q}, res_valid, res_q, e.pair, e.rv, e.res);
      end
    end
  end

  function automatic logic [W-1:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'h8000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h0000_0000;
      3: return 32'h7FFF_FFFF;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (hi_q !== '0 || lo_q !== '0 || res_q !== '0 || res_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 hi=%h lo=%h res=%h rv=%b expected all zero", hi_q, lo_q, res_q, res_valid);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (hi_q !== '0 || lo_q !== '0 || res_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 after release hi=%h lo=%h rv=%b expected 0", hi_q, lo_q, res_valid);
    end
    // R2, R3 extremes
    drive(1, 4'd0, 32'h8000_0000, 32'h8000_0000);
    drive(1, 4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    drive(1, 4'd0, 32'h8000_0000, 32'h7FFF_FFFF);
    drive(1, 4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R4 carry from LO into HI
    drive(1, 4'd7, 32'h0000_0000, 32'h0);
    drive(1, 4'd8, 32'hFFFF_FFFF, 32'h0);
    drive(1, 4'd3, 32'h1, 32'h1);
    drive(1, 4'd2, 32'hFFFF_FFFF, 32'h1);
    // R5 borrow from HI into LO
    drive(1, 4'd7, 32'h1, 32'h0);
    drive(1, 4'd8, 32'h0, 32'h0);
    drive(1, 4'd5, 32'h1, 32'h1);
    drive(1, 4'd4, 32'hFFFF_FFFF, 32'h1);
    // R6, R8 read paths, back-to-back (R10)
    drive(1, 4'd6, 32'hFFFF_FFFE, 32'h0000_0003);
    drive(1, 4'd9, 32'h0, 32'h0);
    drive(1, 4'd10, 32'h0, 32'h0);
    // R9 idle and unused opcodes
    drive(0, 4'd0, 32'h1234_5678, 32'h9);
    for (int op = 11; op < 16; op++) drive(1, 4'(op), 32'hDEAD_BEEF, 32'h5);
    drive(1, 4'd9, 32'h0, 32'h0);
    // Random mix
    for (int i = 0; i < 400; i++)
      drive($urandom_range(0, 7) != 0, 4'($urandom_range(0, 15)), pick(), pick());
    drive(0, 4'd0, 32'h0, 32'h0);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired, got hung run expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule